// File: doc/BRIEF.md
# Piecewise-Linear Code/Temperature Converter

This block turns the ratio code of a resistance-temperature sensor front end into a signed temperature in hundredths of a degree. It also turns a temperature threshold back into a code. The curve is held as a small read-only table of segments. Each row carries four signed 32-bit values: a breakpoint code, the breakpoint temperature in micro-degrees, an offset and a slope. The arithmetic runs in micro-degrees and is scaled down to hundredths only at the end.

One request is taken at a time through a valid/ready handshake. The segment is found by walking the table from its first row, one row per clock. A shared sequential divider then produces the result, truncated toward zero. Every request ends in a one-cycle result strobe. That strobe carries either a value or an error flag for an input outside the table.

Top module: `pwl_conv`

## Requirements
- R1: With `in_rev`=0, the result is (a0 + a1 × code) / 10000, truncated toward zero. The code is the whole 16-bit `in_code`, taken as unsigned. a0 and a1 come from the selected row.
- R2: Rows are scanned from row 0. The scan stops at the first row whose breakpoint is greater than the input, and the row just before it is used. An input equal to an interior breakpoint therefore uses that breakpoint's own row.
- R3: A forward input below the row-0 breakpoint code, or above the last one, ends with `out_err`=1 and `out_result`=0.
- R4: An input exactly equal to the last breakpoint uses the last row and reports no error.
- R5: Negative temperatures truncate toward zero, not toward minus infinity.
- R6: With `in_rev`=1, `in_temp` (hundredths) is multiplied by 10000 to give T. The segment is chosen on the temperature column by the R2 rule. The result is (T − a0) / a1, truncated toward zero. Its low 16 bits go to `out_result[15:0]`, and `out_result[31:16]` is 0.
- R7: A reverse input whose T lies below the row-0 temperature, or above the last row's temperature, ends with `out_err`=1 and `out_result`=0.
- R8: `in_ready` is the inverse of `busy`. `busy` rises in the cycle after a request is accepted. It falls in the cycle in which `out_valid` is high for exactly one cycle. Inputs offered while `busy` is high are ignored.
- R9: After reset, `busy`, `out_valid`, `out_err` and `out_result` are all 0, and `in_ready` is 1.
- R10: The default table has 86 rows. For row k:
  - breakpoint code = 3678 + 800k − 2k²
  - temperature = −200 000 000 + 10 000 000k micro-degrees
  - a1 = 10 000 000 / (798 − 4k), truncated
  - a0 = temperature − a1 × code
  
  Each breakpoint code therefore converts exactly to its own row temperature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_rev | input | 1 | 0: code to temperature, 1: temperature to code |
| in_code | input | 16 | Ratio code for forward requests |
| in_temp | input | 32 | Signed hundredths of a degree for reverse requests |
| busy | output | 1 | A request is in progress |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Input outside the table range |
| out_result | output | 32 | Signed hundredths (forward) or zero-extended code (reverse) |

## Verification
The assertions assume a well-formed table: the breakpoint and temperature columns rise strictly with the row index, and no slope is zero. They also assume the micro-degree intermediate fits the divider width. The stimulus keeps to these assumptions by using only the default table. Reverse temperatures are either inside its range or just outside it, so no scaled value approaches the divider width. Inputs are changed only on the falling edge, and requests are held through busy periods to exercise the ignore rule.

// File: rtl/pwl_pkg.sv
`timescale 1ns/1ps
package pwl_pkg;

  typedef struct packed {
    logic signed [31:0] brk_code;
    logic signed [31:0] brk_temp;
    logic signed [31:0] off_a0;
    logic signed [31:0] slope_a1;
  } seg_row_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_CALC,
    ST_DIV
  } conv_st_t;

  // Default curve: breakpoints spaced for a 10-degree temperature step,
  // with the code step shrinking as the sensor curve flattens.
  function automatic seg_row_t default_row(input int k);
    longint kk, code, temp, span, a1, a0;
    seg_row_t r;
    kk   = longint'(k);
    code = 64'sd3678 + 64'sd800 * kk - 64'sd2 * kk * kk;
    temp = -64'sd200000000 + 64'sd10000000 * kk;
    span = 64'sd798 - 64'sd4 * kk;
    a1   = 64'sd10000000 / span;
    a0   = temp - a1 * code;
    r.brk_code = 32'(code);
    r.brk_temp = 32'(temp);
    r.off_a0   = 32'(a0);
    r.slope_a1 = 32'(a1);
    return r;
  endfunction

endpackage

// File: rtl/pwl_rom.sv
`timescale 1ns/1ps
module pwl_rom
  import pwl_pkg::*;
#(
  parameter int ROWS = 86,
  parameter int AW   = 7
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output seg_row_t      rd_row
);

  seg_row_t mem [ROWS];

  initial begin
    for (int k = 0; k < ROWS; k++) begin
      mem[k] = default_row(k);
    end
  end

  // Registered read so the table maps onto block RAM.
  always_ff @(posedge clk) begin
    rd_row <= mem[rd_addr];
  end

endmodule

// File: rtl/pwl_divider.sv
`timescale 1ns/1ps
module pwl_divider #(
  parameter int DW = 40
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DW-1:0]        num_mag,
  input  logic [DW-1:0]        den_mag,
  input  logic                 neg,
  output logic                 done,
  output logic signed [DW-1:0] quot
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, q_q, d_q;
  logic [CW-1:0] cnt_q;
  logic          neg_q;
  logic [DW:0]   shifted, trial;

  always_comb begin
    shifted = {rem_q, q_q[DW-1]};
    trial   = shifted - {1'b0, d_q};
  end

  // Restoring division on magnitudes, one quotient bit per clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      q_q   <= '0;
      d_q   <= '0;
      cnt_q <= '0;
      neg_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        q_q   <= num_mag;
        d_q   <= den_mag;
        neg_q <= neg;
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        if (trial[DW]) begin
          rem_q <= shifted[DW-1:0];
          q_q   <= {q_q[DW-2:0], 1'b0};
        end else begin
          rem_q <= trial[DW-1:0];
          q_q   <= {q_q[DW-2:0], 1'b1};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done <= 1'b1;
      end
    end
  end

  // Sign applied after the magnitude quotient: truncation toward zero.
  assign quot = neg_q ? -$signed(q_q) : $signed(q_q);

endmodule

// File: rtl/pwl_conv.sv
`timescale 1ns/1ps
module pwl_conv
  import pwl_pkg::*;
#(
  parameter int ROWS   = 86,
  parameter int CODE_W = 16,
  parameter int RES_W  = 32,
  parameter int SCALE  = 10000,
  parameter int DIV_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_rev,
  input  logic [CODE_W-1:0]       in_code,
  input  logic signed [RES_W-1:0] in_temp,
  output logic                    busy,
  output logic                    out_valid,
  output logic                    out_err,
  output logic signed [RES_W-1:0] out_result
);

  localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int KW = 64;
  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  conv_st_t st_q;
  logic                 rev_q;
  logic signed [KW-1:0] key_q;
  logic [AW-1:0]        row_q, row_d;
  seg_row_t             rom_row;
  logic signed [31:0]   prev_a0_q, prev_a1_q, sel_a0_q, sel_a1_q;

  logic signed [KW-1:0] col, fwd_key, rev_key;
  logic                 below;
  logic signed [KW-1:0] a0_x, a1_x, num_x, den_x;
  logic [DIV_W-1:0]     div_num, div_den;
  logic                 div_neg, div_done;
  logic signed [DIV_W-1:0] div_quot;

  assign busy     = (st_q != ST_IDLE);
  assign in_ready = ~busy;

  // Search key: raw code, or hundredths scaled to micro-degrees.
  always_comb begin
    fwd_key = {{(KW-CODE_W){1'b0}}, in_code};
    rev_key = $signed({{(KW-RES_W){in_temp[RES_W-1]}}, in_temp}) * $signed(KW'(SCALE));
  end

  // Column compared during the scan depends on direction.
  always_comb begin
    col   = rev_q ? {{(KW-32){rom_row.brk_temp[31]}}, rom_row.brk_temp}
                  : {{(KW-32){rom_row.brk_code[31]}}, rom_row.brk_code};
    below = (key_q < col);
  end

  // Address for the next table read: the ROM output follows row_q by a clock.
  always_comb begin
    row_d = '0;
    if (st_q == ST_SCAN) begin
      row_d = (!below && row_q != LAST_ROW) ? row_q + 1'b1 : row_q;
    end
  end

  pwl_rom #(.ROWS(ROWS), .AW(AW)) u_rom (
    .clk     (clk),
    .rd_addr (row_d),
    .rd_row  (rom_row)
  );

  // Numerator and divisor for the selected segment.
  always_comb begin
    a0_x    = {{(KW-32){sel_a0_q[31]}}, sel_a0_q};
    a1_x    = {{(KW-32){sel_a1_q[31]}}, sel_a1_q};
    num_x   = rev_q ? (key_q - a0_x) : (a0_x + a1_x * key_q);
    den_x   = rev_q ? a1_x : $signed(KW'(SCALE));
    div_neg = num_x[KW-1] ^ den_x[KW-1];
    div_num = DIV_W'(num_x[KW-1] ? -num_x : num_x);
    div_den = DIV_W'(den_x[KW-1] ? -den_x : den_x);
  end

  pwl_divider #(.DW(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start   (st_q == ST_CALC),
    .num_mag (div_num),
    .den_mag (div_den),
    .neg     (div_neg),
    .done    (div_done),
    .quot    (div_quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      rev_q      <= 1'b0;
      key_q      <= '0;
      row_q      <= '0;
      prev_a0_q  <= '0;
      prev_a1_q  <= '0;
      sel_a0_q   <= '0;
      sel_a1_q   <= '0;
      out_valid  <= 1'b0;
      out_err    <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= 1'b0;
      row_q     <= row_d;
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            rev_q <= in_rev;
            key_q <= in_rev ? rev_key : fwd_key;
            st_q  <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          prev_a0_q <= rom_row.off_a0;
          prev_a1_q <= rom_row.slope_a1;
          if (below) begin
            if (row_q == '0) begin
              out_valid  <= 1'b1;
              out_err    <= 1'b1;
              out_result <= '0;
              st_q       <= ST_IDLE;
            end else begin
              sel_a0_q <= prev_a0_q;
              sel_a1_q <= prev_a1_q;
              st_q     <= ST_CALC;
            end
          end else if (row_q == LAST_ROW) begin
            if (key_q == col) begin
              sel_a0_q <= rom_row.off_a0;
              sel_a1_q <= rom_row.slope_a1;
              st_q     <= ST_CALC;
            end else begin
              out_valid  <= 1'b1;
              out_err    <= 1'b1;
              out_result <= '0;
              st_q       <= ST_IDLE;
            end
          end
        end
        ST_CALC: begin
          st_q <= ST_DIV;
        end
        ST_DIV: begin
          if (div_done) begin
            out_valid  <= 1'b1;
            out_err    <= 1'b0;
            out_result <= rev_q ? $signed(RES_W'(div_quot[CODE_W-1:0]))
                                : $signed(RES_W'(div_quot));
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwl_conv_chk.sv
`timescale 1ns/1ps
module pwl_conv_chk #(
  parameter int ROWS  = 86,
  parameter int RES_W = 32,
  parameter int DIV_W = 40
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    busy,
  input logic                    out_valid,
  input logic                    out_err,
  input logic signed [RES_W-1:0] out_result,
  input logic                    rev_q
);

  localparam int LIMIT = ROWS + DIV_W + 4;

  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= '0;
    else              busy_cnt <= busy_cnt + 1'b1;
  end

  // R8: an accepted request makes the block busy on the next cycle
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> busy);

  // R8: the result strobe coincides with the return to idle
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !busy);

  // R8: the strobe lasts a single cycle
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R8: a request finishes within the scan plus divide window
  p_busy_bound_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_cnt <= 16'(LIMIT)));

  // R3, R7: an error result carries a zero value
  p_err_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_result == '0));

  // R6: a reverse result is a zero-extended 16-bit code
  p_rev_code_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_err && rev_q) |-> (out_result[RES_W-1:16] == '0));

endmodule

bind pwl_conv pwl_conv_chk #(.ROWS(ROWS), .RES_W(RES_W), .DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_err    (out_err),
  .out_result (out_result),
  .rev_q      (rev_q)
);

// File: tb/tb_pwl_conv.sv
`timescale 1ns/1ps
module tb_pwl_conv;

  localparam int ROWS = 86;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_rev = 1'b0;
  logic [15:0] in_code = '0;
  logic signed [31:0] in_temp = '0;
  logic        busy, out_valid, out_err;
  logic signed [31:0] out_result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct {
    logic        err;
    logic [31:0] res;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  pwl_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_rev(in_rev), .in_code(in_code), .in_temp(in_temp), .busy(busy),
    .out_valid(out_valid), .out_err(out_err), .out_result(out_result)
  );

  // Reference table, written from the R10 definition.
  function automatic longint t_code(input int k);
    return 64'sd3678 + 64'sd800 * longint'(k) - 64'sd2 * longint'(k) * longint'(k);
  endfunction
  function automatic longint t_temp(input int k);
    return -64'sd200000000 + 64'sd10000000 * longint'(k);
  endfunction
  function automatic longint t_a1(input int k);
    return 64'sd10000000 / (64'sd798 - 64'sd4 * longint'(k));
  endfunction
  function automatic longint t_a0(input int k);
    return t_temp(k) - t_a1(k) * t_code(k);
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, $signed(act), $signed(expv));
    end
  endtask

  task automatic send(input bit rev, input longint code, input longint temp,
                      input string tag, input int hold);
    exp_t e;
    int i;
    longint v, key;
    e.tag = tag;
    e.err = 1'b0;
    e.res = '0;
    if (!rev) begin
      key = code;
      if (key < t_code(0) || key > t_code(ROWS-1)) e.err = 1'b1;
      else begin
        i = 0;
        while (i < ROWS && key >= t_code(i)) i++;
        i--;
        v = t_a0(i) + t_a1(i) * key;
        e.res = 32'(v / 64'sd10000);
      end
    end else begin
      key = temp * 64'sd10000;
      if (key < t_temp(0) || key > t_temp(ROWS-1)) e.err = 1'b1;
      else begin
        i = 0;
        while (i < ROWS && key >= t_temp(i)) i++;
        i--;
        v = (key - t_a0(i)) / t_a1(i);
        e.res = {16'h0000, 16'(v)};
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_rev   = rev;
    in_code  = 16'(code);
    in_temp  = 32'(temp);
    @(negedge clk);
    if (hold > 0) begin
      // R8: keep a conflicting request present while busy; it must be ignored
      in_code = 16'h0001;
      in_rev  = 1'b0;
      for (int h = 0; h < hold; h++) begin
        check("R8 busy after accept", busy && !in_ready, 32'(busy), 32'd1);
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check("R8 unexpected result", 1'b0, out_result, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " err"}, out_err == e.err, 32'(out_err), 32'(e.err));
        check(e.tag, out_result == e.res, out_result, e.res);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset state", !busy && !out_valid && !out_err && out_result == 0 && in_ready,
          out_result, 32'd0);

    // Forward conversions
    send(0, t_code(0), 0, "R2 first breakpoint", 0);
    send(0, t_code(30) + 100, 0, "R1 mid segment", 0);
    send(0, t_code(47), 0, "R10 interior breakpoint exact", 0);
    send(0, t_code(47) - 1, 0, "R2 just below breakpoint", 0);
    send(0, t_code(0) + 37, 0, "R5 negative truncation", 0);
    send(0, t_code(12) + 211, 0, "R5 negative mid segment", 0);
    send(0, t_code(ROWS-1), 0, "R4 last breakpoint", 0);
    send(0, t_code(ROWS-1) - 1, 0, "R1 below last breakpoint", 0);
    send(0, t_code(0) - 1, 0, "R3 below first", 0);
    send(0, t_code(ROWS-1) + 1, 0, "R3 above last", 0);
    send(0, 64'sd65535, 0, "R3 full scale", 0);
    send(0, 64'sd0, 0, "R3 zero code", 0);

    // Reverse conversions
    send(1, 0, -64'sd20000, "R6 lowest temperature", 0);
    send(1, 0, 64'sd0, "R6 zero degrees", 0);
    send(1, 0, 64'sd12345, "R6 positive", 0);
    send(1, 0, -64'sd15033, "R6 negative", 0);
    send(1, 0, 64'sd65000, "R6 highest temperature", 0);
    send(1, 0, -64'sd20001, "R7 below range", 0);
    send(1, 0, 64'sd65001, "R7 above range", 0);

    // Ignore while busy
    send(0, t_code(1) + 5, 0, "R8 held request", 4);
    send(1, 0, 64'sd31415, "R8 reverse held", 4);

    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 idle after run", !busy && in_ready, 32'(busy), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule